// File: doc/BRIEF.md
# SD Card Clock Divider with Settle Handshake

This block produces the clock for an SD or MMC card from a fixed reference clock, nominally 96 MHz. The reference is divided by a 10-bit integer. Three controls set it up: an internal-clock enable, the divisor and a card-clock enable. A `stable` output tells software when the divided clock has settled.

Software changes the rate in a fixed order. It closes the card-clock enable and drops the internal-clock enable. It then loads the new divisor and raises the internal-clock enable again. When `stable` reads high, it opens the card clock. Software picks the divisor by dividing the reference by the requested rate and adding one if the quotient would still run too fast. The output therefore never exceeds the request. A divisor of 240 gives the 400 kHz identification clock. A divisor of 2 gives 48 MHz, the fastest rate inside the 52 MHz limit. A divisor of 0 or 1 passes the reference straight through.

The output gate changes state only while the divided clock is low. Every pulse that reaches the card is therefore full width.

Top module: `sd_clk_div`

## Requirements
- R1: While reset is asserted, `stable` and `card_clk` are both low.
- R2: `stable` goes high after exactly 4 rising reference edges with `int_clk_en` high. It is low for the first 3 of those edges.
- R3: `stable` goes low in the same cycle that `int_clk_en` falls, with no clock edge needed.
- R4: `divisor` is captured only while `int_clk_en` is low. Changes to it while the internal clock runs do not alter the output period.
- R5: For a divisor N from 2 to 1023, `card_clk` has a period of N reference cycles and stays high for floor(N/2) of them.
- R6: For a divisor of 0 or 1, `card_clk` follows the reference clock: period one reference cycle, high for its high phase.
- R7: `card_clk` stays low until `stable` is high, even when `card_clk_en` is already set.
- R8: The card gate opens and closes only while the divided clock is low. Every high pulse of `card_clk` has the full width of R5 or R6. After `card_clk_en` drops, no further rising edge appears.
- R9: With the divisor chosen by rounding the quotient up, the output rate never exceeds the requested rate. A divisor of 240 yields a 240-cycle period, which is 400 kHz from 96 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_clk_en | input | 1 | Internal divided-clock enable; low also lets `divisor` load |
| divisor | input | 10 | Division ratio; 0 and 1 mean undivided |
| card_clk_en | input | 1 | Request to drive the clock out to the card |
| stable | output | 1 | Divided clock has settled |
| card_clk | output | 1 | Gated clock to the card |

## Verification
The bench timestamps every edge of `card_clk` and checks each period and each high width against values derived from the divisor. Any runt pulse, whether at gate-on, at gate-off or in bypass, shows up as a wrong high width. A gate that opens mid-pulse would produce a short first pulse. A gate that closes late would leave extra rising edges after `card_clk_en` drops.

A design that compares its counter against the live `divisor` pin instead of the captured value would change period when the bench moves the pin mid-run. The smallest ratios (0, 1, 2, 3) and the largest (1023) sit beside random requested rates whose divisors come from the round-up rule. This catches off-by-one counters and a wrong bypass decision.

A `stable` flag that counted one edge too few or too many would fail the exact-cycle probe. So would one that waited for a clock edge to clear.

// File: rtl/sd_clk_div.sv
module sd_clk_div #(
  parameter int DIV_W      = 10,
  parameter int STABLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_clk_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic             card_clk_en,
  output logic             stable,
  output logic             card_clk
);
  localparam int SW = $clog2(STABLE_CYC + 1);

  logic [DIV_W-1:0] div_q, cnt_q, cnt_nxt, half;
  logic [SW-1:0]    settle_q;
  logic             bypass, div_hi_nxt, gate_q, card_q, fast_gate_q;

  assign bypass     = div_q <= DIV_W'(1);
  assign half       = div_q >> 1;
  assign cnt_nxt    = (!int_clk_en || bypass || cnt_q >= div_q - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);
  assign div_hi_nxt = int_clk_en && !bypass && (cnt_nxt < half);
  assign stable     = int_clk_en && (settle_q == SW'(STABLE_CYC));
  assign card_clk   = bypass ? (clk & fast_gate_q) : card_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      cnt_q    <= '0;
      settle_q <= '0;
      gate_q   <= 1'b0;
      card_q   <= 1'b0;
    end else begin
      if (!int_clk_en) div_q <= divisor;
      cnt_q <= cnt_nxt;
      if (!int_clk_en) settle_q <= '0;
      else if (settle_q != SW'(STABLE_CYC)) settle_q <= settle_q + SW'(1);
      if (!int_clk_en) gate_q <= 1'b0;
      else if (!div_hi_nxt) gate_q <= stable && card_clk_en && !bypass;
      card_q <= div_hi_nxt & gate_q;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fast_gate_q <= 1'b0;
    else        fast_gate_q <= int_clk_en && stable && card_clk_en && bypass;
  end

  p_fresh_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clk_en && !$past(int_clk_en)) |-> !stable);

  p_settle_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> ($past(int_clk_en, 1) && $past(int_clk_en, 2) &&
                       $past(int_clk_en, 3) && $past(int_clk_en, 4)));

  p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clk_en && $past(int_clk_en)) |-> $stable(div_q));

  p_quiet_until_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stable |=> !card_q);

  p_gate_moves_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !card_q);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!stable && !card_q));
endmodule

// File: tb/tb_sd_clk_div.sv
`timescale 1ns/1ps
module tb_sd_clk_div;
  logic clk = 1'b0, rst_n = 1'b0, int_clk_en = 1'b0, card_clk_en = 1'b0;
  logic [9:0] divisor = '0;
  logic stable, card_clk;
  int total = 0, bad = 0;

  sd_clk_div dut (.clk(clk), .rst_n(rst_n), .int_clk_en(int_clk_en), .divisor(divisor),
                  .card_clk_en(card_clk_en), .stable(stable), .card_clk(card_clk));

  always #5 clk = ~clk;

  longint t_rise, last_per, last_hi, exp_per, exp_hi;
  bit have_rise;
  int rises, bad_per, bad_hi;

  always @(posedge card_clk) begin
    if (have_rise) begin
      last_per = $time - t_rise;
      if (last_per != exp_per) bad_per++;
    end
    t_rise = $time; have_rise = 1; rises++;
  end
  always @(negedge card_clk) begin
    last_hi = $time - t_rise;
    if (last_hi != exp_hi) bad_hi++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic int pick_div(input longint req);
    longint n = 96000000 / req;
    if (96000000 / n > req) n++;
    return int'(n);
  endfunction

  task automatic run(input int n, input longint req);
    int span = (n < 2) ? 2 : n;
    int r0;
    card_clk_en = 1'b0; int_clk_en = 1'b0;
    @(negedge clk); divisor = 10'(n);
    @(negedge clk);
    have_rise = 0; rises = 0; bad_per = 0; bad_hi = 0;
    exp_per = (n < 2) ? 10 : 10 * n;
    exp_hi  = (n < 2) ? 5 : 10 * (n / 2);
    if (req > 0)
      chk(96000000 / n <= req && (n < 3 || 96000000 / (n - 1) > req), "R9 rate not above request", n, n);
    card_clk_en = 1'b1; int_clk_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(stable == 1'b0, "R2 stable early", stable, 0);
    end
    chk(rises == 0, "R7 card clock before stable", rises, 0);
    @(negedge clk);
    chk(stable == 1'b1, "R2 stable after 4 edges", stable, 1);
    for (int i = 0; i < 6 * span + 20 && rises < 4; i++) @(negedge clk);
    chk(rises >= 4, (n < 2) ? "R6 output running" : "R5 output running", rises, 4);
    chk(bad_per == 0 && last_per == exp_per, (n < 2) ? "R6 period" : "R5 period", last_per, exp_per);
    chk(bad_hi == 0, "R8 full-width pulses", bad_hi, 0);
    divisor = 10'(n ^ 10'h155);
    repeat (3 * span + 2) @(negedge clk);
    chk(bad_per == 0 && last_per == exp_per, "R4 divisor ignored while running", last_per, exp_per);
    repeat ($urandom % span) @(negedge clk);
    card_clk_en = 1'b0;
    repeat (2 * span + 4) @(negedge clk);
    r0 = rises;
    repeat (2 * span + 4) @(negedge clk);
    chk(rises == r0 && bad_hi == 0, "R8 clean stop", rises - r0, 0);
    int_clk_en = 1'b0;
    #1;
    chk(stable == 1'b0, "R3 stable drops at once", stable, 0);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(stable == 1'b0 && card_clk == 1'b0, "R1 reset state", {stable, card_clk}, 0);
    rst_n = 1'b1;
    run(240, 400000);
    run(2, 52000000);
    run(0, 0);
    run(1, 0);
    run(3, 0);
    run(1023, 0);
    for (int k = 0; k < 8; k++) begin
      longint req = 400000 + longint'($urandom % 51600001);
      run(pick_div(req), req);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule